// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block encodes a serial bit stream with a rate-1/2 code of constraint length seven, so the encoder has six memory cells and 64 states. Both generator polynomials, the choice between a feed-forward and a feedback structure, the choice between systematic and non-systematic output, and the two puncturing rows are all configuration inputs. They can be changed between frames without rebuilding the logic. Each coded bit gives up to two output symbols. These are sent one per cycle on a valid/ready stream, symbol 0 ahead of symbol 1.

Software or an upstream sequencer starts a frame with an `init` pulse. Data bits then arrive on the input handshake. At the end of the frame a `frame_term` pulse appends a flush sequence that drives the encoder back to the all-zero state. If `cfg_sub_term` is set, a `sub_end` pulse flushes at each subframe boundary in the same way. Two further modes cover links that need no coding: a pass-through mode and a repeat mode that sends each bit twice.

Top module: `conv_punct_encoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The encoder state and the puncture column are zero.
- R2: With `cfg_mode`=1 and `cfg_recursive`=0, the register input w equals the data bit. Symbol j is the XOR of `cfg_genj & {state, w}`, where bit 0 multiplies w and bit i multiplies the bit entered i steps earlier. The state then shifts w in.
- R3: With `cfg_recursive`=1, the feedback is the XOR of `cfg_gen0[6:1]` with the state, and w is the data bit XOR the feedback. If `cfg_nonsys`=0, symbol 0 is the data bit itself. If `cfg_nonsys`=1, symbol 0 comes from `cfg_gen0`. Symbol 1 always comes from `cfg_gen1`.
- R4: In modes 1 and 2, a 0 at bit `col` of `cfg_punct0` or `cfg_punct1` deletes symbol 0 or symbol 1. `col` starts at 0, advances once per encoded bit and wraps from 6 to 0. A kept symbol 0 is sent before a kept symbol 1.
- R5: In modes 1 and 2, `cfg_inv[0]` inverts every sent symbol 0 and `cfg_inv[1]` inverts every sent symbol 1.
- R6: In mode 0, and in the unused code 3, each input bit is sent as exactly one symbol. It is unchanged, never punctured, and the column does not advance.
- R7: In mode 2, both symbols equal the data bit before inversion, and the encoder state is left unchanged.
- R8: A `frame_term` pulse in mode 1 starts six flush steps, which run once pending symbols have drained. Each step encodes with w=0: the input is 0 when feed-forward and equals the feedback when recursive. The step's symbols are punctured and inverted as usual. `in_ready` stays 0 until all six steps are done, and the state is then zero.
- R9: A `sub_end` pulse starts the same flush only when `cfg_sub_term`=1 and the mode is 1. Otherwise it has no effect. A flush request that arrives while a flush is in progress is ignored.
- R10: `init` clears the state, the column, all pending symbols and any flush in progress. It takes priority over every other input, and `in_ready` is 0 while it is high.
- R11: While `out_valid`=1, `in_ready`=0. While `out_valid`=1 and `out_ready`=0, `out_sym` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gen0 | input | 7 | Generator polynomial of symbol 0, also the feedback taps |
| cfg_gen1 | input | 7 | Generator polynomial of symbol 1 |
| cfg_recursive | input | 1 | 1 selects feedback coding |
| cfg_nonsys | input | 1 | 1 makes recursive symbol 0 non-systematic |
| cfg_punct0 | input | 7 | Puncture row for symbol 0 |
| cfg_punct1 | input | 7 | Puncture row for symbol 1 |
| cfg_mode | input | 2 | 0 pass-through, 1 coding, 2 repeat |
| cfg_inv | input | 2 | Per-symbol inversion |
| cfg_sub_term | input | 1 | Enable flush on subframe end |
| init | input | 1 | Restart encoder |
| frame_term | input | 1 | End-of-frame flush request |
| sub_end | input | 1 | End-of-subframe flush request |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Input data bit |
| in_ready | output | 1 | Input bit accepted when high with in_valid |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | 1 | Output symbol |
| out_ready | input | 1 | Consumer accepts the symbol |

## Verification
The first kept symbol of a bit accepted at a clock edge appears one cycle later. The second kept symbol follows on the cycle after the first one is taken. `in_ready` falls in the same cycle the first symbol appears, and rises again in the cycle after the last one is taken. A flush step is taken at the first edge where no symbols are pending, and its symbols are due one cycle after that step. The reference model advances at each rising edge from the inputs it drove, and the outputs are compared against it at each falling edge. Every result is therefore checked in exactly the cycle it is due, including the cycles where `in_ready` must be 0 during a flush or under backpressure.

// File: rtl/conv_punct_encoder.sv
module conv_punct_encoder #(
  parameter int K    = 7,
  parameter int PLEN = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [K-1:0]    cfg_gen0,
  input  logic [K-1:0]    cfg_gen1,
  input  logic            cfg_recursive,
  input  logic            cfg_nonsys,
  input  logic [PLEN-1:0] cfg_punct0,
  input  logic [PLEN-1:0] cfg_punct1,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_inv,
  input  logic            cfg_sub_term,
  input  logic            init,
  input  logic            frame_term,
  input  logic            sub_end,
  input  logic            in_valid,
  input  logic            in_bit,
  output logic            in_ready,
  output logic            out_valid,
  output logic            out_sym,
  input  logic            out_ready
);
  localparam int MEM = K - 1;
  localparam int TW  = $clog2(MEM + 1);
  localparam int CW  = $clog2(PLEN);

  logic [MEM-1:0] st;
  logic [CW-1:0]  col;
  logic [TW-1:0]  tcnt;
  logic [1:0]     pend;
  logic [1:0]     sym;

  wire busy_term = (tcnt != '0);
  wire idle_out  = (pend == 2'b00);

  assign in_ready  = idle_out && !busy_term && !init;
  assign out_valid = !idle_out;
  assign out_sym   = pend[0] ? sym[0] : sym[1];

  wire step_in   = in_valid && in_ready;
  wire step_term = idle_out && busy_term && !init;
  wire step      = step_in || step_term;

  wire conv_m  = (cfg_mode == 2'd1);
  wire rep_m   = (cfg_mode == 2'd2);
  wire coded_m = conv_m || rep_m;

  wire fb  = cfg_recursive & (^(cfg_gen0[K-1:1] & st));
  wire u   = step_term ? fb : in_bit;
  wire w   = u ^ fb;
  wire [K-1:0] win = {st, w};
  wire par0 = ^(cfg_gen0 & win);
  wire par1 = ^(cfg_gen1 & win);

  wire c0 = rep_m ? u : ((cfg_recursive && !cfg_nonsys) ? u : par0);
  wire c1 = rep_m ? u : par1;

  wire start_term = (frame_term || (sub_end && cfg_sub_term)) && conv_m && !busy_term && !init;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      st   <= '0;
      col  <= '0;
      tcnt <= '0;
      pend <= 2'b00;
      sym  <= 2'b00;
    end else begin
      if (out_valid && out_ready) begin
        if (pend[0]) pend[0] <= 1'b0;
        else         pend[1] <= 1'b0;
      end
      if (step) begin
        if (coded_m) begin
          pend <= {cfg_punct1[col], cfg_punct0[col]};
          sym  <= {c1 ^ cfg_inv[1], c0 ^ cfg_inv[0]};
          col  <= (col == CW'(PLEN - 1)) ? '0 : col + 1'b1;
          if (conv_m) st <= {st[MEM-2:0], w};
        end else begin
          pend <= 2'b01;
          sym  <= {1'b0, u};
        end
      end
      if (start_term)     tcnt <= TW'(MEM);
      else if (step_term) tcnt <= tcnt - 1'b1;
    end
  end
endmodule

module conv_punct_encoder_chk #(
  parameter int MEM = 6,
  parameter int TW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           init,
  input logic           in_valid,
  input logic           in_bit,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_sym,
  input logic           out_ready,
  input logic [1:0]     cfg_mode,
  input logic [MEM-1:0] st,
  input logic [TW-1:0]  tcnt,
  input logic           step_term
);
  AST_HOLD_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !init) |=> (out_valid && $stable(out_sym))); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R11
  AST_INIT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!out_valid && st == '0)); // R10
  AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_term && tcnt == TW'(1)) |=> (st == '0)); // R8
  AST_TERM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt != '0) |-> !in_ready); // R8
  AST_PASS_ONE: assert property (@(posedge clk) disable iff (!rst_n || init)
    (in_valid && in_ready && cfg_mode == 2'd0) |=> (out_valid && out_sym == $past(in_bit))); // R6
endmodule

bind conv_punct_encoder conv_punct_encoder_chk #(.MEM(MEM), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid), .in_bit(in_bit),
  .in_ready(in_ready), .out_valid(out_valid), .out_sym(out_sym), .out_ready(out_ready),
  .cfg_mode(cfg_mode), .st(st), .tcnt(tcnt), .step_term(step_term)
);

// File: tb/conv_punct_encoder_tb.sv
`timescale 1ns/1ps
module conv_punct_encoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cfg_gen0 = 7'h79, cfg_gen1 = 7'h5B, cfg_punct0 = 7'h7F, cfg_punct1 = 7'h7F;
  logic cfg_recursive = 0, cfg_nonsys = 0, cfg_sub_term = 0;
  logic [1:0] cfg_mode = 0, cfg_inv = 0;
  logic init = 0, frame_term = 0, sub_end = 0, in_valid = 0, in_bit = 0, out_ready = 1;
  logic in_ready, out_valid, out_sym;

  always #2.5 clk = ~clk;

  conv_punct_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_gen0(cfg_gen0), .cfg_gen1(cfg_gen1),
    .cfg_recursive(cfg_recursive), .cfg_nonsys(cfg_nonsys), .cfg_punct0(cfg_punct0),
    .cfg_punct1(cfg_punct1), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
    .cfg_sub_term(cfg_sub_term), .init(init), .frame_term(frame_term), .sub_end(sub_end),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
    .out_sym(out_sym), .out_ready(out_ready)
  );

  int checks = 0, failures = 0;
  bit done = 0, live = 0;
  string cur_req = "R1";

  bit q[$];
  int m_st = 0, m_col = 0, m_t = 0;

  function automatic int par(int x);
    return $countones(x) & 1;
  endfunction

  task automatic m_step(input int u_in, input bit term);
    int fb, u, w, win, c0, c1;
    fb = cfg_recursive ? par((int'(cfg_gen0) >> 1) & m_st) : 0;
    u  = term ? fb : u_in;
    if (cfg_mode == 0 || cfg_mode == 3) begin
      q.push_back(u[0]);
      return;
    end
    if (cfg_mode == 2) begin
      c0 = u; c1 = u;
    end else begin
      w   = u ^ fb;
      win = (m_st << 1) | w;
      c0  = (cfg_recursive && !cfg_nonsys) ? u : par(int'(cfg_gen0) & win);
      c1  = par(int'(cfg_gen1) & win);
      m_st = win & 63;
    end
    if (cfg_punct0[m_col]) q.push_back(c0[0] ^ cfg_inv[0]);
    if (cfg_punct1[m_col]) q.push_back(c1[0] ^ cfg_inv[1]);
    m_col = (m_col + 1) % 7;
  endtask

  always @(posedge clk) begin
    if (!rst_n || init) begin
      q.delete(); m_st = 0; m_col = 0; m_t = 0;
    end else begin
      int tprev;
      bit empty0;
      tprev  = m_t;
      empty0 = (q.size() == 0);
      if (!empty0 && out_ready) void'(q.pop_front());
      if (empty0 && tprev == 0 && in_valid) m_step(int'(in_bit), 1'b0);
      else if (empty0 && tprev > 0) begin
        m_step(0, 1'b1);
        m_t = m_t - 1;
      end
      if ((frame_term || (sub_end && cfg_sub_term)) && cfg_mode == 1 && tprev == 0) m_t = 6;
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(in_ready, (q.size() == 0) && (m_t == 0) && !init, "in_ready");
      chk(out_valid, q.size() != 0, "out_valid");
      if (q.size() != 0) chk(out_sym, q[0], "out_sym");
    end
  end

  task automatic run(input int n, input int rdy_pct);
    for (int i = 0; i < n; i++) begin
      in_bit    = 1'($urandom % 2);
      out_ready = (($urandom % 100) < rdy_pct);
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_term(input bit sub);
    if (sub) sub_end = 1; else frame_term = 1;
    run(1, 80);
    sub_end = 0; frame_term = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    cur_req = "R1";
    chk(out_valid, 1'b0, "reset out_valid");
    chk(in_ready, 1'b1, "reset in_ready");
    live = 1;
    in_valid = 1;

    cur_req = "R6"; cfg_mode = 0; cfg_inv = 2'b11; cfg_punct0 = 7'h00;
    run(40, 70);
    cur_req = "R2"; cfg_mode = 1; cfg_inv = 0; cfg_punct0 = 7'h7F; cfg_punct1 = 7'h7F;
    run(80, 75);
    cur_req = "R4"; cfg_punct0 = 7'b1011011; cfg_punct1 = 7'b0110101;
    run(100, 60);
    cur_req = "R5"; cfg_inv = 2'b10; run(40, 80); cfg_inv = 2'b01; run(40, 80);
    cfg_inv = 0; cfg_punct0 = 7'h7F; cfg_punct1 = 7'h7F;
    cur_req = "R8"; pulse_term(0); run(40, 70);
    cur_req = "R3"; cfg_recursive = 1; cfg_nonsys = 0; run(60, 75);
    cfg_nonsys = 1; run(60, 75);
    cur_req = "R8"; cfg_punct1 = 7'b1101110; pulse_term(0); run(40, 50);
    pulse_term(0); pulse_term(0); run(30, 90);
    cur_req = "R9"; cfg_sub_term = 0; pulse_term(1); run(20, 80);
    cfg_sub_term = 1; pulse_term(1); run(30, 80);
    cfg_recursive = 0; pulse_term(1); run(30, 80);
    cur_req = "R10"; run(3, 0); init = 1; run(2, 50); init = 0; run(30, 80);
    pulse_term(0); run(2, 0); init = 1; run(1, 50); init = 0; run(30, 80);
    cur_req = "R7"; cfg_mode = 2; cfg_inv = 2'b01; cfg_punct0 = 7'b1110111;
    pulse_term(0); run(60, 70);
    cfg_mode = 1; cfg_inv = 0; run(20, 80);
    cur_req = "R11"; run(15, 0); run(30, 30); run(10, 100);
    cur_req = "R6"; cfg_mode = 3; run(20, 70);

    in_valid = 0;
    run(10, 100);
    done = 1;
    summary();
    $finish;
  end
endmodule